// File: doc/BRIEF.md
# Paged External Memory Space Decoder

This block sits between the core or DMA address path and the off-chip bus pins. It treats the upper eight bits of a 24-bit word address as a page number, where each page spans 64K words. It then works out which off-chip space the access targets. The choices are one of four external banks, a boot space, or an I/O space whose address is built from a page register and an instruction immediate. If the access belongs on chip, it reports that instead. Page 255 holds the on-chip boot ROM and never reaches an external pin.

Every space has its own settings for read and write wait counts, strobe polarity and bus width. The block runs each accepted access on its own. It drives the chosen select and the strobe for the programmed number of wait states, then pulses a ready output. Software sets the bank page limits, the I/O page and the per-space settings through a small write port. These settings are captured when an access is accepted, so a later write cannot disturb an access that is already running.

Top module: `extmem_space_decoder`

## Requirements
- R1: With reset limits, an external-space access selects bank 0 for pages 1–63, bank 1 for 64–127, bank 2 for 128–191 and bank 3 for 192–254. Page 0 asserts no select. bankSel bit n is bank n.
- R2: An external-space access to page 255 asserts no select and no strobe, and its ready pulse comes with onChipHit high.
- R3: Writing cfgSel 8+n (data bits 7:0) sets the last page of bank n. Bank n starts one page after bank n−1's last page, and bank 0 starts at page 1. When several banks match, the lowest-numbered one wins.
- R4: A boot-space access (reqSpace 1) asserts bootSel for pages 0–62 and no select for page 63 and above.
- R5: ioAddr always equals the I/O page register (cfgSel 12, data bits 7:0) in bits 17:10, concatenated with ioImm in bits 9:0.
- R6: An I/O-space access (reqSpace 2) asserts ioSel only when the 18-bit I/O address is 8192 or more. Below 8192 it asserts no select.
- R7: Space settings are written at cfgSel 0–3 (banks), 4 (boot) and 5 (I/O). The fields are bits 3:0 read wait W, bits 7:4 write wait W, bit 8 active-low and bit 9 16-bit width. The reset value of each is W=3, active-low, 16-bit. The strobe and select stay active for W+1 cycles, with W chosen by reqWrite.
- R8: accReady pulses for one cycle right after the strobe ends. An access with no external target pulses accReady, together with onChipHit, in the cycle after acceptance.
- R9: The strobe is inverted when the space is active-low. Between accesses the strobe sits at the inactive level of the last space that had a target, which is high after reset.
- R10: busWide shows the width bit of the space being accessed while its strobe is active.
- R11: At most one select is active at a time, and only while busy.
- R12: reqValid is ignored while busy, and such a request produces no access and no ready pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrite | input | 1 | Settings write enable |
| cfgSel | input | 4 | Settings register index |
| cfgData | input | 10 | Settings write data |
| reqValid | input | 1 | Access request |
| reqSpace | input | 2 | 0 external, 1 boot, 2 I/O |
| reqWrite | input | 1 | 1 for write, selects write wait count |
| reqAddr | input | 24 | Word address; bits 23:16 are the page |
| ioImm | input | 10 | Instruction immediate for I/O space |
| busy | output | 1 | Access in progress |
| bankSel | output | 4 | External bank selects |
| bootSel | output | 1 | Boot space select |
| ioSel | output | 1 | I/O space select |
| strobe | output | 1 | Access strobe, polarity applied |
| busWide | output | 1 | 1 for a 16-bit bus, 0 for 8-bit |
| accReady | output | 1 | One-cycle access completion pulse |
| onChipHit | output | 1 | With accReady: access had no external target |
| ioAddr | output | 18 | Assembled I/O address |
| busAddr | output | 24 | Address latched for the current access |

## Verification
A request is accepted on the rising edge where reqValid is high and busy is low. The select and strobe come up in the cycle after that edge and stay up for W+1 cycles. accReady follows in the next single cycle, and a request with no target raises accReady one cycle after acceptance. ioAddr is combinational and is due in the same cycle its inputs change. The monitor samples on the falling edge. It counts the strobe-active cycles between acceptance and the ready pulse, and compares that count and the select seen against the expected item at the head of the queue. Any ready pulse with an empty queue is reported against the busy-ignore requirement.

// File: rtl/extmem_pkg.sv
package extmem_pkg;
  localparam int WAIT_W = 4;

  typedef enum logic [1:0] {
    SP_EXT  = 2'd0,
    SP_BOOT = 2'd1,
    SP_IO   = 2'd2
  } spaceT;

  // bit 9 width, bit 8 active-low, bits 7:4 write wait, bits 3:0 read wait
  typedef struct packed {
    logic              wide;
    logic              activeLow;
    logic [WAIT_W-1:0] wrWait;
    logic [WAIT_W-1:0] rdWait;
  } spaceCfgT;

  typedef struct packed {
    logic latchReq;
    logic decCount;
    logic driveBus;
    logic signalDone;
  } ctrlStrobeT;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACTIVE = 2'd1,
    ST_DONE   = 2'd2
  } stateT;
endpackage

// File: rtl/extmem_ctrl.sv
module extmem_ctrl
  import extmem_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqHasTarget,
  input  logic       countZero,
  output ctrlStrobeT ctrl,
  output logic       busy
);
  stateT state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    ctrl      = '0;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          ctrl.latchReq = 1'b1;
          stateNext     = reqHasTarget ? ST_ACTIVE : ST_DONE;
        end
      end
      ST_ACTIVE: begin
        ctrl.driveBus = 1'b1;
        if (countZero) stateNext = ST_DONE;
        else           ctrl.decCount = 1'b1;
      end
      ST_DONE: begin
        ctrl.signalDone = 1'b1;
        stateNext       = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE);
endmodule

// File: rtl/extmem_datapath.sv
module extmem_datapath
  import extmem_pkg::*;
#(
  parameter int ADDR_W         = 24,
  parameter int PAGE_W         = 8,
  parameter int NUM_BANKS      = 4,
  parameter int IO_IMM_W       = 10,
  parameter int BOOT_PAGES     = 63,
  parameter int FIRST_EXT_PAGE = 1,
  parameter int IO_RESERVED    = 8192,
  parameter int CFG_SEL_W      = 4,
  parameter int DEF_WAIT       = 3
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          cfgWrite,
  input  logic [CFG_SEL_W-1:0]          cfgSel,
  input  logic [$bits(spaceCfgT)-1:0]   cfgData,
  input  logic [1:0]                    reqSpace,
  input  logic                          reqWrite,
  input  logic [ADDR_W-1:0]             reqAddr,
  input  logic [IO_IMM_W-1:0]           ioImm,
  input  ctrlStrobeT                    ctrl,
  output logic                          reqHasTarget,
  output logic                          countZero,
  output logic [NUM_BANKS-1:0]          bankSel,
  output logic                          bootSel,
  output logic                          ioSel,
  output logic                          strobe,
  output logic                          busWide,
  output logic                          onChipHit,
  output logic [PAGE_W+IO_IMM_W-1:0]    ioAddr,
  output logic [ADDR_W-1:0]             busAddr
);
  localparam int IO_ADDR_W   = PAGE_W + IO_IMM_W;
  localparam int ROM_PAGE    = (2 ** PAGE_W) - 1;
  localparam int SEL_N       = NUM_BANKS + 2;
  localparam int BOOT_IDX    = NUM_BANKS;
  localparam int IO_IDX      = NUM_BANKS + 1;
  localparam int TOP_BASE    = 2 ** $clog2(SEL_N);
  localparam int IO_PAGE_SEL = TOP_BASE + NUM_BANKS;
  localparam int PAGE_SPAN   = (ROM_PAGE + 1) / NUM_BANKS;

  spaceCfgT              spaceCfg [SEL_N];
  logic [PAGE_W-1:0]     bankTop  [NUM_BANKS];
  logic [PAGE_W-1:0]     ioPage;

  // settings registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < SEL_N; i++) begin
        spaceCfg[i].wide      <= 1'b1;
        spaceCfg[i].activeLow <= 1'b1;
        spaceCfg[i].wrWait    <= WAIT_W'(DEF_WAIT);
        spaceCfg[i].rdWait    <= WAIT_W'(DEF_WAIT);
      end
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (b == NUM_BANKS - 1) bankTop[b] <= PAGE_W'(ROM_PAGE - 1);
        else                    bankTop[b] <= PAGE_W'((b + 1) * PAGE_SPAN - 1);
      end
      ioPage <= '0;
    end else if (cfgWrite) begin
      for (int i = 0; i < SEL_N; i++)
        if (int'(cfgSel) == i) spaceCfg[i] <= spaceCfgT'(cfgData);
      for (int b = 0; b < NUM_BANKS; b++)
        if (int'(cfgSel) == TOP_BASE + b) bankTop[b] <= cfgData[PAGE_W-1:0];
      if (int'(cfgSel) == IO_PAGE_SEL) ioPage <= cfgData[PAGE_W-1:0];
    end
  end

  // page decode
  logic [PAGE_W-1:0]     page;
  logic [NUM_BANKS-1:0]  bankHit;
  logic [NUM_BANKS-1:0]  bankOne;
  logic [IO_ADDR_W-1:0]  ioFull;

  assign page   = reqAddr[ADDR_W-1 -: PAGE_W];
  assign ioFull = {ioPage, ioImm};
  assign ioAddr = ioFull;

  for (genvar gb = 0; gb < NUM_BANKS; gb++) begin : g_bank
    logic [PAGE_W:0] lowLim;
    if (gb == 0) begin : g_first
      assign lowLim = (PAGE_W + 1)'(FIRST_EXT_PAGE);
    end else begin : g_next
      assign lowLim = {1'b0, bankTop[gb-1]} + (PAGE_W + 1)'(1);
    end
    assign bankHit[gb] = ({1'b0, page} >= lowLim) && (page <= bankTop[gb])
                         && (page != PAGE_W'(ROM_PAGE));
  end

  always_comb begin
    logic found;
    found   = 1'b0;
    bankOne = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bankHit[b] && !found) begin
        bankOne[b] = 1'b1;
        found      = 1'b1;
      end
    end
  end

  logic [SEL_N-1:0] selNext;
  always_comb begin
    selNext = '0;
    case (spaceT'(reqSpace))
      SP_EXT:  selNext[NUM_BANKS-1:0] = bankOne;
      SP_BOOT: selNext[BOOT_IDX]      = (page < PAGE_W'(BOOT_PAGES));
      SP_IO:   selNext[IO_IDX]        = (ioFull >= IO_ADDR_W'(IO_RESERVED));
      default: selNext = '0;
    endcase
  end
  assign reqHasTarget = |selNext;

  spaceCfgT           pickCfg;
  logic [WAIT_W-1:0]  waitPick;
  always_comb begin
    pickCfg = spaceCfg[0];
    for (int i = 0; i < SEL_N; i++)
      if (selNext[i]) pickCfg = spaceCfg[i];
  end
  assign waitPick = reqWrite ? pickCfg.wrWait : pickCfg.rdWait;

  // per-access state
  logic [SEL_N-1:0]  tgtSel;
  logic [WAIT_W-1:0] count;
  logic              activeLowQ;
  logic              wideQ;
  logic [ADDR_W-1:0] busAddrQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tgtSel     <= '0;
      count      <= '0;
      activeLowQ <= 1'b1;
      wideQ      <= 1'b1;
      busAddrQ   <= '0;
    end else if (ctrl.latchReq) begin
      tgtSel   <= selNext;
      count    <= waitPick;
      busAddrQ <= (spaceT'(reqSpace) == SP_IO) ? ADDR_W'(ioFull) : reqAddr;
      if (|selNext) begin
        activeLowQ <= pickCfg.activeLow;
        wideQ      <= pickCfg.wide;
      end
    end else if (ctrl.decCount) begin
      count <= count - 1'b1;
    end
  end

  assign countZero = (count == '0);
  assign bankSel   = tgtSel[NUM_BANKS-1:0] & {NUM_BANKS{ctrl.driveBus}};
  assign bootSel   = tgtSel[BOOT_IDX] & ctrl.driveBus;
  assign ioSel     = tgtSel[IO_IDX] & ctrl.driveBus;
  assign strobe    = ctrl.driveBus ^ activeLowQ;
  assign busWide   = wideQ;
  assign onChipHit = ctrl.signalDone & ~(|tgtSel);
  assign busAddr   = busAddrQ;
endmodule

// File: rtl/extmem_space_decoder.sv
module extmem_space_decoder
  import extmem_pkg::*;
#(
  parameter int ADDR_W         = 24,
  parameter int PAGE_W         = 8,
  parameter int NUM_BANKS      = 4,
  parameter int IO_IMM_W       = 10,
  parameter int BOOT_PAGES     = 63,
  parameter int FIRST_EXT_PAGE = 1,
  parameter int IO_RESERVED    = 8192,
  parameter int CFG_SEL_W      = 4,
  parameter int DEF_WAIT       = 3
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         cfgWrite,
  input  logic [CFG_SEL_W-1:0]         cfgSel,
  input  logic [$bits(spaceCfgT)-1:0]  cfgData,
  input  logic                         reqValid,
  input  logic [1:0]                   reqSpace,
  input  logic                         reqWrite,
  input  logic [ADDR_W-1:0]            reqAddr,
  input  logic [IO_IMM_W-1:0]          ioImm,
  output logic                         busy,
  output logic [NUM_BANKS-1:0]         bankSel,
  output logic                         bootSel,
  output logic                         ioSel,
  output logic                         strobe,
  output logic                         busWide,
  output logic                         accReady,
  output logic                         onChipHit,
  output logic [PAGE_W+IO_IMM_W-1:0]   ioAddr,
  output logic [ADDR_W-1:0]            busAddr
);
  ctrlStrobeT ctrl;
  logic       reqHasTarget;
  logic       countZero;

  extmem_ctrl i_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .reqValid     (reqValid),
    .reqHasTarget (reqHasTarget),
    .countZero    (countZero),
    .ctrl         (ctrl),
    .busy         (busy)
  );

  extmem_datapath #(
    .ADDR_W         (ADDR_W),
    .PAGE_W         (PAGE_W),
    .NUM_BANKS      (NUM_BANKS),
    .IO_IMM_W       (IO_IMM_W),
    .BOOT_PAGES     (BOOT_PAGES),
    .FIRST_EXT_PAGE (FIRST_EXT_PAGE),
    .IO_RESERVED    (IO_RESERVED),
    .CFG_SEL_W      (CFG_SEL_W),
    .DEF_WAIT       (DEF_WAIT)
  ) i_dp (
    .clk          (clk),
    .rstN         (rstN),
    .cfgWrite     (cfgWrite),
    .cfgSel       (cfgSel),
    .cfgData      (cfgData),
    .reqSpace     (reqSpace),
    .reqWrite     (reqWrite),
    .reqAddr      (reqAddr),
    .ioImm        (ioImm),
    .ctrl         (ctrl),
    .reqHasTarget (reqHasTarget),
    .countZero    (countZero),
    .bankSel      (bankSel),
    .bootSel      (bootSel),
    .ioSel        (ioSel),
    .strobe       (strobe),
    .busWide      (busWide),
    .onChipHit    (onChipHit),
    .ioAddr       (ioAddr),
    .busAddr      (busAddr)
  );

  assign accReady = ctrl.signalDone;
endmodule

// File: rtl/extmem_checker.sv
module extmem_checker #(
  parameter int NUM_BANKS   = 4,
  parameter int PAGE_W      = 8,
  parameter int IO_ADDR_W   = 18,
  parameter int IO_RESERVED = 8192
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 reqValid,
  input logic [1:0]           reqSpace,
  input logic [PAGE_W-1:0]    reqPage,
  input logic [IO_ADDR_W-1:0] ioAddr,
  input logic                 busy,
  input logic [NUM_BANKS-1:0] bankSel,
  input logic                 bootSel,
  input logic                 ioSel,
  input logic                 accReady,
  input logic                 onChipHit
);
  logic [NUM_BANKS+1:0] sels;
  assign sels = {ioSel, bootSel, bankSel};

  p_sel_onehot_r11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(sels));

  p_sel_busy_r11: assert property (@(posedge clk) disable iff (!rstN)
    (|sels) |-> busy);

  p_rom_none_r2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !busy && reqSpace == 2'd0 && reqPage == {PAGE_W{1'b1}})
      |=> (accReady && onChipHit && !(|sels)));

  p_io_reserved_r6: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !busy && reqSpace == 2'd2 && ioAddr < IO_ADDR_W'(IO_RESERVED))
      |=> !ioSel);

  p_ready_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    accReady |=> !accReady);

  p_ready_after_sel_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(|sels) |-> accReady);
endmodule

bind extmem_space_decoder extmem_checker #(
  .NUM_BANKS   (NUM_BANKS),
  .PAGE_W      (PAGE_W),
  .IO_ADDR_W   (PAGE_W + IO_IMM_W),
  .IO_RESERVED (IO_RESERVED)
) i_checker (
  .clk       (clk),
  .rstN      (rstN),
  .reqValid  (reqValid),
  .reqSpace  (reqSpace),
  .reqPage   (reqAddr[ADDR_W-1 -: PAGE_W]),
  .ioAddr    (ioAddr),
  .busy      (busy),
  .bankSel   (bankSel),
  .bootSel   (bootSel),
  .ioSel     (ioSel),
  .accReady  (accReady),
  .onChipHit (onChipHit)
);

// File: tb/test_extmem_space_decoder.sv
module test_extmem_space_decoder;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrite = 1'b0;
  logic [3:0]  cfgSel = '0;
  logic [9:0]  cfgData = '0;
  logic        reqValid = 1'b0;
  logic [1:0]  reqSpace = '0;
  logic        reqWrite = 1'b0;
  logic [23:0] reqAddr = '0;
  logic [9:0]  ioImm = '0;
  logic        busy, bootSel, ioSel, strobe, busWide, accReady, onChipHit;
  logic [3:0]  bankSel;
  logic [17:0] ioAddr;
  logic [23:0] busAddr;

  extmem_space_decoder i_extmem_space_decoder (.*);

  always #5 clk = ~clk;

  typedef struct {
    int         cycles;
    logic [5:0] sel;
    logic       wide;
    logic       onChip;
    logic       inact;
    string      tag;
  } expT;

  expT        q[$];
  expT        e;
  int         compared = 0;
  int         mismatched = 0;
  int         pushCount = 0;
  int         doneCount = 0;
  int         tbTop[4] = '{63, 127, 191, 254};
  logic [9:0] tbCfg[6] = '{10'h333, 10'h333, 10'h333, 10'h333, 10'h333, 10'h333};
  int         tbIoPage = 0;
  logic       tbIdle = 1'b1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [5:0] refSel(input int sp, input int page, input int ioFull);
    refSel = '0;
    if (sp == 0) begin
      for (int b = 0; b < 4; b++) begin
        int lo;
        lo = (b == 0) ? 1 : tbTop[b-1] + 1;
        if (page >= lo && page <= tbTop[b] && page != 255) return 6'(1 << b);
      end
    end else if (sp == 1) begin
      if (page < 63) refSel = 6'b01_0000;
    end else if (sp == 2) begin
      if (ioFull >= 8192) refSel = 6'b10_0000;
    end
  endfunction

  task automatic cfgWr(input int sel, input logic [9:0] data);
    @(negedge clk); #1;
    cfgWrite = 1'b1; cfgSel = 4'(sel); cfgData = data;
    @(negedge clk); #1;
    cfgWrite = 1'b0;
    if (sel < 6) tbCfg[sel] = data;
    else if (sel >= 8 && sel < 12) tbTop[sel-8] = int'(data[7:0]);
    else if (sel == 12) tbIoPage = int'(data[7:0]);
  endtask

  task automatic access(input int sp, input int page, input logic wr,
                        input int imm, input string tag);
    expT  x;
    int   idx;
    int   w;
    logic [5:0] s;
    @(negedge clk);
    while (busy) @(negedge clk);
    #1;
    s = refSel(sp, page, tbIoPage * 1024 + imm);
    idx = 0;
    for (int i = 0; i < 6; i++) if (s[i]) idx = i;
    w = wr ? int'(tbCfg[idx][7:4]) : int'(tbCfg[idx][3:0]);
    x.sel    = s;
    x.cycles = (s != 0) ? w + 1 : 0;
    x.wide   = tbCfg[idx][9];
    x.onChip = (s == 0);
    x.inact  = (s != 0) ? tbCfg[idx][8] : tbIdle;
    x.tag    = tag;
    if (s != 0) tbIdle = tbCfg[idx][8];
    reqValid = 1'b1; reqSpace = 2'(sp); reqWrite = wr;
    reqAddr = {8'(page), 16'h1234}; ioImm = 10'(imm);
    q.push_back(x);
    pushCount++;
    @(negedge clk); #1;
    reqValid = 1'b0;
  endtask

  task automatic waitIdle();
    @(negedge clk);
    while (busy || q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // monitor / scoreboard
  int         cnt = 0;
  logic [5:0] selSeen = '0;
  logic       wideSeen = 1'b0;
  always @(negedge clk) begin
    if (rstN) begin
      if (q.size() > 0) begin
        if (strobe !== q[0].inact) begin
          cnt++;
          selSeen  = selSeen | {ioSel, bootSel, bankSel};
          wideSeen = busWide;
        end
        if (accReady) begin
          e = q.pop_front();
          doneCount++;
          chk(cnt == e.cycles, "R7", {e.tag, " strobe cycles"}, cnt, e.cycles);
          chk(selSeen == e.sel, "R1", {e.tag, " select"}, selSeen, e.sel);
          chk(onChipHit == e.onChip, "R8", {e.tag, " onChipHit"}, onChipHit, e.onChip);
          if (e.sel != 0)
            chk(wideSeen == e.wide, "R10", {e.tag, " width"}, wideSeen, e.wide);
          cnt = 0;
          selSeen = '0;
        end
      end else begin
        if (accReady) begin
          doneCount++;
          chk(1'b0, "R12", "unexpected ready", 1, 0);
        end
        if (!busy)
          chk(strobe === tbIdle, "R9", "idle strobe level", strobe, tbIdle);
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    mismatched++;
    $display("FAIL R8 watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(strobe === 1'b1, "R9", "reset strobe", strobe, 1);
    chk({ioSel, bootSel, bankSel} === 6'b0, "R11", "reset selects", {ioSel, bootSel, bankSel}, 0);
    chk(busy === 1'b0 && accReady === 1'b0, "R8", "reset busy/ready", {busy, accReady}, 0);
    #1 rstN = 1'b1;

    // R1 / R2: reset limits
    access(0, 8'h00, 0, 0, "R2 page0");
    access(0, 8'h01, 0, 0, "R1 p01");
    access(0, 8'h3F, 0, 0, "R1 p3F");
    access(0, 8'h40, 0, 0, "R1 p40");
    access(0, 8'h80, 1, 0, "R1 p80");
    access(0, 8'hC0, 0, 0, "R1 pC0");
    access(0, 8'hFE, 0, 0, "R1 pFE");
    access(0, 8'hFF, 0, 0, "R2 rom");
    waitIdle();

    // R7 / R9 / R10: bank1 read wait 0, write wait 5, active-high, 8-bit
    cfgWr(1, {1'b0, 1'b0, 4'd5, 4'd0});
    access(0, 8'h50, 0, 0, "R7 rd0");
    access(0, 8'h50, 1, 0, "R7 wr5");
    waitIdle();
    chk(strobe === 1'b0, "R9", "idle after active-high", strobe, 0);
    access(0, 8'h10, 0, 0, "R9 back low");
    waitIdle();
    chk(strobe === 1'b1, "R9", "idle after active-low", strobe, 1);

    // R4 boot
    access(1, 8'h00, 0, 0, "R4 b00");
    access(1, 8'h3E, 0, 0, "R4 b3E");
    access(1, 8'h3F, 0, 0, "R4 b3F");
    waitIdle();

    // R5 / R6 I/O
    cfgWr(12, 10'h07);
    @(negedge clk); #1 ioImm = 10'h3FF; #1;
    chk(ioAddr === 18'h1FFF, "R5", "io addr 07/3FF", ioAddr, 18'h1FFF);
    access(2, 0, 0, 10'h3FF, "R6 io 1FFF");
    waitIdle();
    cfgWr(12, 10'h08);
    @(negedge clk); #1 ioImm = 10'h155; #1;
    chk(ioAddr === 18'h2155, "R5", "io addr 08/155", ioAddr, 18'h2155);
    cfgWr(5, {1'b0, 1'b1, 4'd2, 4'd1});
    access(2, 0, 0, 10'h000, "R6 io 2000");
    access(2, 0, 1, 10'h155, "R6 io 2155 wr");
    waitIdle();

    // R3 programmable limits, non-monotonic resolution
    cfgWr(8, 10'h010);
    access(0, 8'h11, 0, 0, "R3 p11 bank1");
    access(0, 8'h10, 0, 0, "R3 p10 bank0");
    cfgWr(9, 10'h005);
    cfgWr(10, 10'h090);
    access(0, 8'h20, 0, 0, "R3 p20 bank2");
    cfgWr(8, 10'h0A0);
    access(0, 8'h20, 0, 0, "R3 p20 lowest");
    waitIdle();

    // R12 request while busy is dropped
    access(0, 8'hC8, 1, 0, "R12 main");
    @(negedge clk); #1;
    reqValid = 1'b1; reqSpace = 2'd0; reqAddr = 24'h011234;
    @(negedge clk); #1;
    reqValid = 1'b0;
    waitIdle();
    repeat (5) @(negedge clk);
    chk(doneCount == pushCount, "R12", "ready count", doneCount, pushCount);
    chk(q.size() == 0, "R8", "outstanding items", q.size(), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule